// File: doc/BRIEF.md
# Transceiver Reconfiguration Read-Modify-Write Sequencer

This block is a memory-mapped bus master that reconfigures a set of serial transceiver channels one after another. For every channel it first claims the channel's internal configuration controller with a fixed ownership write. It then walks a fixed table of register offsets. For each offset it reads the register, changes only the bits selected by a per-entry mask, and writes the result back. Finally it returns ownership with a second fixed write.

Once the last channel has been released, the block pulses a request to an external transceiver reset controller. It waits for that controller to report ready, then signals completion with a one-cycle pulse and returns to idle.

The table of offsets, masks and values, the channel count and the address span of each channel are elaboration parameters. Software or a higher-level manager only has to pulse `start_i` and wait for `done_o`.

Top module: `xcvr_rmw_sequencer`

## Requirements
- R1: While reset is held and after it is released, `mm_read_o`, `mm_write_o`, `done_o` and `xrst_req_o` are low.
- R2: `start_i` is acted on only while the block is idle. A start pulse during a run does not change the bus traffic of that run and does not add a second completion.
- R3: Each channel's work begins with a write of data 0x02 to that channel's base address plus offset 0x00.
- R4: For each table entry, in table order (entry 0 first), the block reads base+offset. It then writes (read & ~mask) | (value & mask) to the same address, so bits outside the mask keep their old value.
- R5: After the last table entry of a channel, the block writes data 0x03 to base+0x00. It then moves to the next channel, or to the reset phase after the last one.
- R6: A channel's base address is channel_index × CH_SPAN. Channels are processed in ascending index order, and the base is added to every address of that channel, including the ownership register.
- R7: `mm_read_o` and `mm_write_o` are never high together. While a request is held off by `mm_wait_i`, the address, write data and command stay unchanged.
- R8: A read is complete only when `mm_rvalid_i` is seen in a cycle after the read was accepted (`mm_wait_i` low). The data on `mm_rdata_i` in that cycle is the data that is merged.
- R9: `xrst_req_o` is high for exactly one cycle, and only after the last release write has been accepted. `rst_ready_i` is only looked at after that cycle.
- R10: `done_o` is a one-cycle pulse in the cycle after `xrst_ready_i` is sampled high following the request. The block is then idle and accepts a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a full reconfiguration pass (used only when idle) |
| done_o | output | 1 | One-cycle completion pulse |
| mm_addr_o | output | ADDR_W | Bus address |
| mm_read_o | output | 1 | Bus read command |
| mm_write_o | output | 1 | Bus write command |
| mm_wdata_o | output | DATA_W | Bus write data |
| mm_rdata_i | input | DATA_W | Bus read data |
| mm_wait_i | input | 1 | Slave stall; the command is accepted in a cycle where this is low |
| mm_rvalid_i | input | 1 | Read data valid |
| xrst_req_o | output | 1 | One-cycle request to the transceiver reset controller |
| xrst_ready_i | input | 1 | Reset controller ready |

## Verification
A bus command is taken by the slave model at the clock edge where `mm_wait_i` is low. The model therefore records each write, and schedules each read reply, on the falling edge just before that edge. Read data returns one to three cycles after acceptance, and the captured value shows up in a write-back two cycles after `mm_rvalid_i` at the earliest.

The reset request is noted on the falling edge where it is high, and the ready input is raised one to four cycles later. `done_o` is due exactly one cycle after the falling edge on which ready was raised, so the bench checks it there and checks it low again one cycle later. Write logs, read logs and final register contents are compared after `done_o`, against a sequence and a bit-by-bit merge that the bench computes itself.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INIT,
    ST_INIT_WR,
    ST_RD,
    ST_MOD,
    ST_WR,
    ST_TRANS,
    ST_END_INIT,
    ST_END_INIT_WR,
    ST_RESET,
    ST_DONE
  } xrs_state_t;

  // Fixed ownership codes written to register 0x00 of each channel
  localparam logic [7:0] XRS_OWN_TAKE = 8'h02;
  localparam logic [7:0] XRS_OWN_GIVE = 8'h03;

endpackage

// File: rtl/xrs_table.sv
module xrs_table #(
  parameter int NUM_OFS = 3,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int OI_W    = 2,
  parameter logic [NUM_OFS-1:0][ADDR_W-1:0] OFS_LIST  = '0,
  parameter logic [NUM_OFS-1:0][DATA_W-1:0] MASK_LIST = '0,
  parameter logic [NUM_OFS-1:0][DATA_W-1:0] VAL_LIST  = '0
) (
  input  logic [OI_W-1:0]   idx_i,
  output logic [ADDR_W-1:0] ofs_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] val_o
);

  logic [ADDR_W-1:0] ofs_a  [NUM_OFS];
  logic [DATA_W-1:0] mask_a [NUM_OFS];
  logic [DATA_W-1:0] val_a  [NUM_OFS];

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ent
    assign ofs_a[g]  = OFS_LIST[g];
    assign mask_a[g] = MASK_LIST[g];
    assign val_a[g]  = VAL_LIST[g];
  end

  assign ofs_o  = ofs_a[idx_i];
  assign mask_o = mask_a[idx_i];
  assign val_o  = val_a[idx_i];

endmodule

// File: rtl/xrs_fsm.sv
module xrs_fsm
  import xrs_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int NUM_OFS = 3,
  parameter int CH_W    = 1,
  parameter int OI_W    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            mm_wait_i,
  input  logic            mm_rvalid_i,
  input  logic            rst_ready_i,
  output xrs_state_t      state_o,
  output logic [CH_W-1:0] ch_o,
  output logic [OI_W-1:0] oi_o,
  output logic            rd_cmd_o,
  output logic            wr_cmd_o,
  output logic            req_o,
  output logic            done_o,
  output logic            ev_rd_done_o
);

  xrs_state_t      st, nxt;
  logic [CH_W-1:0] ch;
  logic [OI_W-1:0] oi;
  logic            rd_pend;
  logic            req_sent;
  logic            last_ofs, last_ch;

  assign last_ofs     = (oi == OI_W'(NUM_OFS - 1));
  assign last_ch      = (ch == CH_W'(NUM_CH - 1));
  assign rd_cmd_o     = (st == ST_RD) && !rd_pend;
  assign wr_cmd_o     = (st == ST_INIT_WR) || (st == ST_WR) || (st == ST_END_INIT_WR);
  assign ev_rd_done_o = (st == ST_RD) && rd_pend && mm_rvalid_i;
  assign req_o        = (st == ST_RESET) && !req_sent;
  assign done_o       = (st == ST_DONE);

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:        if (start_i) nxt = ST_INIT;
      ST_INIT:        nxt = ST_INIT_WR;
      ST_INIT_WR:     if (!mm_wait_i) nxt = ST_RD;
      ST_RD:          if (ev_rd_done_o) nxt = ST_MOD;
      ST_MOD:         nxt = ST_WR;
      ST_WR:          if (!mm_wait_i) nxt = ST_TRANS;
      ST_TRANS:       nxt = last_ofs ? ST_END_INIT : ST_RD;
      ST_END_INIT:    nxt = ST_END_INIT_WR;
      ST_END_INIT_WR: if (!mm_wait_i) nxt = last_ch ? ST_RESET : ST_INIT;
      ST_RESET:       if (req_sent && rst_ready_i) nxt = ST_DONE;
      ST_DONE:        nxt = ST_IDLE;
      default:        nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ch       <= '0;
      oi       <= '0;
      rd_pend  <= 1'b0;
      req_sent <= 1'b0;
    end else begin
      st       <= nxt;
      req_sent <= (st == ST_RESET);
      if (st == ST_IDLE && start_i) ch <= '0;
      if (st == ST_END_INIT_WR && !mm_wait_i && !last_ch) ch <= ch + CH_W'(1);
      if (st == ST_INIT_WR && !mm_wait_i) oi <= '0;
      if (st == ST_TRANS && !last_ofs) oi <= oi + OI_W'(1);
      if (rd_cmd_o && !mm_wait_i) rd_pend <= 1'b1;
      else if (ev_rd_done_o) rd_pend <= 1'b0;
    end
  end

  assign state_o = st;
  assign ch_o    = ch;
  assign oi_o    = oi;

endmodule

// File: rtl/xrs_datapath.sv
module xrs_datapath
  import xrs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CH_W   = 1,
  parameter logic [ADDR_W-1:0] CH_SPAN = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xrs_state_t        state_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [ADDR_W-1:0] ofs_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              rd_capture_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);

  function automatic logic [DATA_W-1:0] merge_bits(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] mask_v,
    input logic [DATA_W-1:0] new_v);
    return (old_v & ~mask_v) | (new_v & mask_v);
  endfunction

  function automatic logic [ADDR_W-1:0] chan_base(input logic [CH_W-1:0] c);
    return ADDR_W'(c) * CH_SPAN;
  endfunction

  logic              own_phase;
  logic [ADDR_W-1:0] base;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] wdata_q;

  assign own_phase = (state_i == ST_INIT) || (state_i == ST_INIT_WR) ||
                     (state_i == ST_END_INIT) || (state_i == ST_END_INIT_WR);
  assign base      = chan_base(ch_i);
  assign addr_o    = own_phase ? base : base + ofs_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wdata_q <= '0;
    end else begin
      if (rd_capture_i) rd_q <= rdata_i;
      case (state_i)
        ST_INIT:     wdata_q <= DATA_W'(XRS_OWN_TAKE);
        ST_END_INIT: wdata_q <= DATA_W'(XRS_OWN_GIVE);
        ST_MOD:      wdata_q <= merge_bits(rd_q, mask_i, val_i);
        default:     wdata_q <= wdata_q;
      endcase
    end
  end

  assign wdata_o = wdata_q;

endmodule

// File: rtl/xcvr_rmw_sequencer.sv
module xcvr_rmw_sequencer
  import xrs_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int NUM_OFS = 3,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter logic [ADDR_W-1:0] CH_SPAN = 16'h0100,
  parameter logic [NUM_OFS-1:0][ADDR_W-1:0] OFS_LIST  = {16'h0044, 16'h0020, 16'h0008},
  parameter logic [NUM_OFS-1:0][DATA_W-1:0] MASK_LIST = {32'hFF00_0000, 32'h0000_00F0, 32'h0001_0003},
  parameter logic [NUM_OFS-1:0][DATA_W-1:0] VAL_LIST  = {32'h5A00_0000, 32'h0000_0060, 32'h0001_0002}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] mm_addr_o,
  output logic              mm_read_o,
  output logic              mm_write_o,
  output logic [DATA_W-1:0] mm_wdata_o,
  input  logic [DATA_W-1:0] mm_rdata_i,
  input  logic              mm_wait_i,
  input  logic              mm_rvalid_i,
  output logic              xrst_req_o,
  input  logic              xrst_ready_i
);

  localparam int CH_W = (NUM_CH  > 1) ? $clog2(NUM_CH)  : 1;
  localparam int OI_W = (NUM_OFS > 1) ? $clog2(NUM_OFS) : 1;

  xrs_state_t        st;
  logic [CH_W-1:0]   ch;
  logic [OI_W-1:0]   oi;
  logic [ADDR_W-1:0] ent_ofs;
  logic [DATA_W-1:0] ent_mask, ent_val;
  logic              ev_rd_done;

  xrs_fsm #(.NUM_CH(NUM_CH), .NUM_OFS(NUM_OFS), .CH_W(CH_W), .OI_W(OI_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .mm_wait_i(mm_wait_i), .mm_rvalid_i(mm_rvalid_i), .rst_ready_i(xrst_ready_i),
    .state_o(st), .ch_o(ch), .oi_o(oi),
    .rd_cmd_o(mm_read_o), .wr_cmd_o(mm_write_o),
    .req_o(xrst_req_o), .done_o(done_o), .ev_rd_done_o(ev_rd_done)
  );

  xrs_table #(.NUM_OFS(NUM_OFS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OI_W(OI_W),
              .OFS_LIST(OFS_LIST), .MASK_LIST(MASK_LIST), .VAL_LIST(VAL_LIST)) u_tab (
    .idx_i(oi), .ofs_o(ent_ofs), .mask_o(ent_mask), .val_o(ent_val)
  );

  xrs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W), .CH_SPAN(CH_SPAN)) u_dp (
    .clk(clk), .rst_n(rst_n), .state_i(st), .ch_i(ch),
    .ofs_i(ent_ofs), .mask_i(ent_mask), .val_i(ent_val),
    .rdata_i(mm_rdata_i), .rd_capture_i(ev_rd_done),
    .addr_o(mm_addr_o), .wdata_o(mm_wdata_o)
  );

endmodule

// File: rtl/xrs_checker.sv
module xrs_checker
  import xrs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input xrs_state_t        state,
  input logic              mm_read_o,
  input logic              mm_write_o,
  input logic [ADDR_W-1:0] mm_addr_o,
  input logic [DATA_W-1:0] mm_wdata_o,
  input logic              mm_wait_i,
  input logic              ev_rd_done,
  input logic              done_o,
  input logic              xrst_req_o,
  input logic              xrst_ready_i
);

  AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(mm_read_o && mm_write_o)); // R7

  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_read_o || mm_write_o) && mm_wait_i |=>
      (mm_read_o == $past(mm_read_o)) && (mm_write_o == $past(mm_write_o)) &&
      $stable(mm_addr_o) && $stable(mm_wdata_o)); // R7

  AST_TAKE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INIT_WR) |-> (mm_wdata_o == DATA_W'(XRS_OWN_TAKE))); // R3

  AST_GIVE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_END_INIT_WR) |-> (mm_wdata_o == DATA_W'(XRS_OWN_GIVE))); // R5

  AST_MERGE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MOD) |-> $past(ev_rd_done)); // R8

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xrst_req_o |=> !xrst_req_o); // R9

  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(xrst_ready_i)); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !mm_read_o && !mm_write_o); // R10

endmodule

bind xcvr_rmw_sequencer xrs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(st),
  .mm_read_o(mm_read_o), .mm_write_o(mm_write_o),
  .mm_addr_o(mm_addr_o), .mm_wdata_o(mm_wdata_o), .mm_wait_i(mm_wait_i),
  .ev_rd_done(ev_rd_done), .done_o(done_o),
  .xrst_req_o(xrst_req_o), .xrst_ready_i(xrst_ready_i)
);

// File: tb/tb_xcvr_rmw_sequencer.sv
`timescale 1ns/1ps
module tb_xcvr_rmw_sequencer;

  localparam int NCH  = 2;
  localparam int NOFS = 3;
  localparam int SPAN = 'h100;
  localparam int WR_PER_RUN = NCH * (NOFS + 2);

  int unsigned t_ofs  [NOFS] = '{'h0008, 'h0020, 'h0044};
  int unsigned t_mask [NOFS] = '{32'h0001_0003, 32'h0000_00F0, 32'hFF00_0000};
  int unsigned t_val  [NOFS] = '{32'h0001_0002, 32'h0000_0060, 32'h5A00_0000};

  logic        clk = 0, rst_n = 0, start_i = 0;
  logic        done_o, mm_read_o, mm_write_o, xrst_req_o;
  logic [15:0] mm_addr_o;
  logic [31:0] mm_wdata_o, mm_rdata_i;
  logic        mm_wait_i = 0, mm_rvalid_i = 0, xrst_ready_i = 0;

  xcvr_rmw_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .mm_addr_o(mm_addr_o), .mm_read_o(mm_read_o), .mm_write_o(mm_write_o),
    .mm_wdata_o(mm_wdata_o), .mm_rdata_i(mm_rdata_i), .mm_wait_i(mm_wait_i),
    .mm_rvalid_i(mm_rvalid_i), .xrst_req_o(xrst_req_o), .xrst_ready_i(xrst_ready_i)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  int wait_pct = 0, force_wait = 0;
  int rd_cnt = 0, rdy_cnt = 0, rdy_cyc = -10, done_cyc = -10;
  int done_cnt = 0, req_cnt = 0;
  logic [31:0] rd_hold;
  int unsigned mem [int];
  int unsigned wr_a [$];
  int unsigned wr_d [$];
  int unsigned rd_a [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned bench_merge(int unsigned old_v, int unsigned m, int unsigned v);
    int unsigned r = 0;
    for (int b = 0; b < 32; b++)
      r[b] = m[b] ? v[b] : old_v[b];
    return r;
  endfunction

  // Bus slave and reset-controller model; everything decided on falling edges
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      mm_wait_i = 0; mm_rvalid_i = 0; rd_cnt = 0; xrst_ready_i = 0; rdy_cnt = 0;
    end else begin
      mm_rvalid_i = 0;
      mm_rdata_i  = $urandom;
      if (rd_cnt > 0) begin
        rd_cnt--;
        if (rd_cnt == 0) begin mm_rvalid_i = 1; mm_rdata_i = rd_hold; end
      end
      if (force_wait > 0) begin mm_wait_i = 1; force_wait--; end
      else mm_wait_i = ($urandom_range(99) < wait_pct);
      if ((mm_read_o || mm_write_o) && !mm_wait_i) begin
        if (mm_write_o) begin
          mem[int'(mm_addr_o)] = mm_wdata_o;
          wr_a.push_back(mm_addr_o); wr_d.push_back(mm_wdata_o);
        end else begin
          rd_hold = mem.exists(int'(mm_addr_o)) ? mem[int'(mm_addr_o)] : 0;
          rd_a.push_back(mm_addr_o);
          rd_cnt = $urandom_range(3, 1);
        end
      end
      // reset controller
      if (done_o) begin
        done_cnt++;
        chk(rdy_cyc == cyc - 1, "R10", "done one cycle after ready", cyc - rdy_cyc, 1);
        done_cyc = cyc;
        xrst_ready_i = 0;
      end
      if (cyc == done_cyc + 1)
        chk(!done_o, "R10", "done is a single-cycle pulse", done_o, 0);
      if (rdy_cnt > 0) begin
        rdy_cnt--;
        if (rdy_cnt == 0) begin xrst_ready_i = 1; rdy_cyc = cyc; end
      end
      if (xrst_req_o) begin
        req_cnt++;
        chk(wr_a.size() == WR_PER_RUN, "R9", "request only after last release", wr_a.size(), WR_PER_RUN);
        rdy_cnt = $urandom_range(4, 1);
      end
    end
  end

  task automatic run_once(input int wp, input bit poke, input int stall);
    int unsigned init_v [NCH][NOFS];
    int d0, q0, idx;
    bit timed_out;
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < NOFS; i++) begin
        init_v[c][i] = $urandom;
        mem[c * SPAN + int'(t_ofs[i])] = init_v[c][i];
      end
    wr_a.delete(); wr_d.delete(); rd_a.delete();
    wait_pct = wp; d0 = done_cnt; q0 = req_cnt;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0; force_wait = stall;
    if (poke) begin
      repeat (4) @(negedge clk);
      start_i = 1; @(negedge clk); start_i = 0;
    end
    timed_out = 1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (done_cnt > d0) begin timed_out = 0; break; end
    end
    chk(!timed_out, "R10", "run completes", timed_out, 0);
    repeat (8) @(negedge clk);
    chk(done_cnt - d0 == 1, "R2", "exactly one done per run", done_cnt - d0, 1);
    chk(req_cnt - q0 == 1, "R9", "exactly one reset request", req_cnt - q0, 1);
    chk(wr_a.size() == WR_PER_RUN, "R2", "write count", wr_a.size(), WR_PER_RUN);
    chk(rd_a.size() == NCH * NOFS, "R8", "read count", rd_a.size(), NCH * NOFS);
    if (wr_a.size() == WR_PER_RUN && rd_a.size() == NCH * NOFS) begin
      idx = 0;
      for (int c = 0; c < NCH; c++) begin
        chk(wr_a[idx] == c * SPAN && wr_d[idx] == 2, "R3", "ownership take addr",
            wr_a[idx], c * SPAN);
        idx++;
        for (int i = 0; i < NOFS; i++) begin
          chk(rd_a[c * NOFS + i] == c * SPAN + t_ofs[i], "R6", "read address",
              rd_a[c * NOFS + i], c * SPAN + t_ofs[i]);
          chk(wr_a[idx] == c * SPAN + t_ofs[i], "R4", "write-back address",
              wr_a[idx], c * SPAN + t_ofs[i]);
          chk(wr_d[idx] == bench_merge(init_v[c][i], t_mask[i], t_val[i]), "R4",
              "merged data", wr_d[idx], bench_merge(init_v[c][i], t_mask[i], t_val[i]));
          idx++;
        end
        chk(wr_a[idx] == c * SPAN && wr_d[idx] == 3, "R5", "ownership give data",
            wr_d[idx], 3);
        idx++;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!mm_read_o && !mm_write_o && !done_o && !xrst_req_o, "R1", "outputs in reset",
        {mm_read_o, mm_write_o, done_o, xrst_req_o}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!mm_read_o && !mm_write_o && !done_o && !xrst_req_o, "R1", "outputs after reset",
        {mm_read_o, mm_write_o, done_o, xrst_req_o}, 0);
    void'($urandom(32'h5EED_0017));
    run_once(0, 0, 0);     // R4 no stalls
    run_once(0, 0, 25);    // R7 long stall on the first ownership write
    run_once(30, 1, 0);    // R2 start poked mid-run
    for (int r = 0; r < 4; r++)
      run_once($urandom_range(70, 10), r[0], $urandom_range(6));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule